// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block turns a short host opcode into the full series of bus cycles that a NAND flash device expects. Software writes a start request and a five-bit opcode into a control register. The sequencer then drives command-latch cycles, address-latch cycles, status and identification reads, and the waits for the page data port, on a flash pin interface. That interface has chip select, command and address latch enables, read and write strobes, and an I/O bus that is either 8 or 16 bits wide.

The register block holds the settings the sequences depend on. These are the bus width, the address geometry (address cycle count and page size) and a 26-bit page index. It also holds the completion status bit and the interrupt enable mask. Captured identification and status words are read back through the same register port. The page data streaming itself belongs to a separate data port. Toward that port the sequencer raises a data-phase indication and waits for its done pulse.

Top module: `nandCmdSeq`

## Requirements
- R1: Register map (word addresses): 0x0 status, 0x1 control, 0x2 width (bit 0 set = 16-bit bus), 0x3 geometry, 0x4 page index, 0x5 ID low word, 0x6 ID high word, 0x7 interrupt enable, 0x8 status clear. A control write starts a command only if bit 7 is set; the opcode comes from bits 12:8. Reading control returns the opcode of the last accepted command at bits 12:8, with all other bits 0.
- R2: Opcode 0x02 issues the single command byte 0xFF.
- R3: Opcode 0x01 issues command 0x90, then one address byte 0x00, then reads. An 8-bit bus makes five byte reads: the first four fill ID low bits 7:0, 15:8, 23:16 and 31:24, and the fifth is the ID high word, zero-extended. A 16-bit bus makes three reads: halfwords into ID low bits 15:0 and 31:16, then the ID high word, zero-extended.
- R4: Opcode 0x04 issues command 0x70 and then one read, which is stored zero-extended in the ID high word.
- R5: Address cycle count is 3 plus geometry bits 11:10. A full address is column low byte, column high byte, row bits 7:0, then row bits 15:8 if the count is at least 4, then row bits 23:16 if it is at least 5. Row bytes come from the page index.
- R6: Opcode 0x11 (erase) issues 0x60, only the row bytes, then 0xD0, and then chains a status read (0x70 plus one read).
- R7: Opcode 0x05 (page read) issues 0x00, a full address with column 0, and 0x30. It then stays busy with the data-phase output high and completion clear until a data-done pulse arrives.
- R8: Opcode 0x10 (program) issues 0x80 and a full address with column 0, then waits with the data-phase and write-direction outputs high. After data-done it issues 0x10 and then a chained status read.
- R9: The spare opcodes use a column equal to the page size selected by geometry bits 9:8 (0 gives 512, 2 gives 4096, any other value gives 2048). Opcode 0x06 issues 0x00, the address and 0x30. Opcode 0x13 issues 0x80, the address, 0x10 and a chained status read.
- R10: Status bit 2 (complete) is 0 after reset and is cleared when a command starts. It is set when the sequencer returns to idle. In that same cycle chip select goes high and both latch enables go low.
- R11: irq is high when interrupt-enable bit 7 is set and any of enable bits 3:0 meets a set status bit among bits 5:2. Writing 1s to bits 3:0 of the clear register clears the matching status bits. A completion in the same cycle takes priority over the clear.
- R12: Any opcode outside the listed set produces no flash cycles and completes at once.
- R13: A start request that arrives while a command is running is ignored. It neither alters the opcode readback nor adds flash cycles.
- R14: Every write cycle holds chip select low and pulls the write strobe low for exactly one clock. The command latch enable is high for command bytes and the address latch enable is high for address bytes, never both at once. Every read cycle pulls the read strobe low for exactly one clock, and the input bus is captured at the clock edge that ends that low clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write enable |
| regAddr | input | 4 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational from regAddr) |
| irq | output | 1 | Interrupt request |
| dataDone | input | 1 | Pulse from the data port ending a data phase |
| dataActive | output | 1 | Sequencer is waiting in a page data phase |
| dataWrite | output | 1 | Direction of the current data phase (1 = program) |
| flashCeN | output | 1 | Chip select, active low |
| flashCle | output | 1 | Command latch enable |
| flashAle | output | 1 | Address latch enable |
| flashWeN | output | 1 | Write strobe, active low |
| flashReN | output | 1 | Read strobe, active low |
| flashIoOut | output | 16 | I/O bus output value |
| flashIoOe | output | 1 | I/O bus output enable |
| flashIoIn | input | 16 | I/O bus input value |

## Verification
The assertions assume that the data port pulses dataDone only while dataActive is high, and only for one clock. They also assume that the width and geometry registers stay unchanged while a command runs, since the sequencer reads them live. The bench stays inside these limits: it writes configuration only while the block is idle, and it raises dataDone for a single clock only after it has seen dataActive high. Its flash model answers each read strobe on the falling clock edge, so the input bus is stable before the capturing edge.

// File: rtl/nandSeqPkg.sv
package nandSeqPkg;

  localparam int REG_AW = 4;
  localparam int REG_DW = 32;
  localparam int IO_W   = 16;

  localparam logic [REG_AW-1:0] RA_STATUS = 4'h0;
  localparam logic [REG_AW-1:0] RA_CTRL   = 4'h1;
  localparam logic [REG_AW-1:0] RA_WIDTH  = 4'h2;
  localparam logic [REG_AW-1:0] RA_GEOM   = 4'h3;
  localparam logic [REG_AW-1:0] RA_PAGE   = 4'h4;
  localparam logic [REG_AW-1:0] RA_IDLO   = 4'h5;
  localparam logic [REG_AW-1:0] RA_IDHI   = 4'h6;
  localparam logic [REG_AW-1:0] RA_IEN    = 4'h7;
  localparam logic [REG_AW-1:0] RA_ICLR   = 4'h8;

  localparam logic [4:0] OP_READ_ID    = 5'h01;
  localparam logic [4:0] OP_RESET      = 5'h02;
  localparam logic [4:0] OP_STATUS     = 5'h04;
  localparam logic [4:0] OP_READ_PAGE  = 5'h05;
  localparam logic [4:0] OP_READ_SPARE = 5'h06;
  localparam logic [4:0] OP_PROGRAM    = 5'h10;
  localparam logic [4:0] OP_ERASE      = 5'h11;
  localparam logic [4:0] OP_WR_SPARE   = 5'h13;

  typedef enum logic [2:0] {
    K_END, K_CMD, K_ADDR_FULL, K_ADDR_ROW, K_ADDR_ID, K_READ_ID, K_READ_ST, K_WAIT
  } phaseKind_e;

  typedef struct packed {
    phaseKind_e kind;
    logic [7:0] code;
    logic       spareCol;
  } phase_t;

  typedef enum logic [1:0] {CAP_NONE, CAP_ID, CAP_STAT} capSel_e;

  // Strobes from the sequencer control to the pin datapath
  typedef struct packed {
    logic       select;
    logic       cmdLatch;
    logic       addrLatch;
    logic       wrStrobe;
    logic       rdStrobe;
    logic [7:0] ioByte;
    capSel_e    capSel;
    logic [2:0] capIdx;
  } pinCtl_t;

  function automatic phase_t mkPh(phaseKind_e k, logic [7:0] c, logic s);
    phase_t p;
    p.kind = k;
    p.code = c;
    p.spareCol = s;
    return p;
  endfunction

  // Phase list of each host opcode; the phase after the last one is K_END
  function automatic phase_t phaseOf(logic [4:0] op, logic [2:0] ph);
    phase_t p;
    p = mkPh(K_END, 8'h00, 1'b0);
    case (op)
      OP_READ_ID: case (ph)
        3'd0: p = mkPh(K_CMD, 8'h90, 1'b0);
        3'd1: p = mkPh(K_ADDR_ID, 8'h00, 1'b0);
        3'd2: p = mkPh(K_READ_ID, 8'h00, 1'b0);
        default: ;
      endcase
      OP_RESET: case (ph)
        3'd0: p = mkPh(K_CMD, 8'hFF, 1'b0);
        default: ;
      endcase
      OP_STATUS: case (ph)
        3'd0: p = mkPh(K_CMD, 8'h70, 1'b0);
        3'd1: p = mkPh(K_READ_ST, 8'h00, 1'b0);
        default: ;
      endcase
      OP_READ_PAGE: case (ph)
        3'd0: p = mkPh(K_CMD, 8'h00, 1'b0);
        3'd1: p = mkPh(K_ADDR_FULL, 8'h00, 1'b0);
        3'd2: p = mkPh(K_CMD, 8'h30, 1'b0);
        3'd3: p = mkPh(K_WAIT, 8'h00, 1'b0);
        default: ;
      endcase
      OP_READ_SPARE: case (ph)
        3'd0: p = mkPh(K_CMD, 8'h00, 1'b0);
        3'd1: p = mkPh(K_ADDR_FULL, 8'h00, 1'b1);
        3'd2: p = mkPh(K_CMD, 8'h30, 1'b0);
        default: ;
      endcase
      OP_PROGRAM: case (ph)
        3'd0: p = mkPh(K_CMD, 8'h80, 1'b0);
        3'd1: p = mkPh(K_ADDR_FULL, 8'h00, 1'b0);
        3'd2: p = mkPh(K_WAIT, 8'h00, 1'b0);
        3'd3: p = mkPh(K_CMD, 8'h10, 1'b0);
        3'd4: p = mkPh(K_CMD, 8'h70, 1'b0);
        3'd5: p = mkPh(K_READ_ST, 8'h00, 1'b0);
        default: ;
      endcase
      OP_ERASE: case (ph)
        3'd0: p = mkPh(K_CMD, 8'h60, 1'b0);
        3'd1: p = mkPh(K_ADDR_ROW, 8'h00, 1'b0);
        3'd2: p = mkPh(K_CMD, 8'hD0, 1'b0);
        3'd3: p = mkPh(K_CMD, 8'h70, 1'b0);
        3'd4: p = mkPh(K_READ_ST, 8'h00, 1'b0);
        default: ;
      endcase
      OP_WR_SPARE: case (ph)
        3'd0: p = mkPh(K_CMD, 8'h80, 1'b0);
        3'd1: p = mkPh(K_ADDR_FULL, 8'h00, 1'b1);
        3'd2: p = mkPh(K_CMD, 8'h10, 1'b0);
        3'd3: p = mkPh(K_CMD, 8'h70, 1'b0);
        3'd4: p = mkPh(K_READ_ST, 8'h00, 1'b0);
        default: ;
      endcase
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/nandSeqRegs.sv
module nandSeqRegs
  import nandSeqPkg::*;
#(
  parameter int ROW_W = 26,
  parameter int COL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWdata,
  output logic [REG_DW-1:0] regRdata,
  output logic              irq,
  input  logic              busy,
  input  logic              cmdDone,
  input  logic [REG_DW-1:0] idLo,
  input  logic [REG_DW-1:0] idHi,
  output logic              start,
  output logic [4:0]        startOp,
  output logic              wide,
  output logic [2:0]        addrCycles,
  output logic [COL_W-1:0]  spareCol,
  output logic [ROW_W-1:0]  rowAddr
);

  logic [4:0]       opReg;
  logic             wideReg;
  logic [1:0]       extraCyc;
  logic [1:0]       pageSel;
  logic [ROW_W-1:0] pageReg;
  logic             ienOn;
  logic [3:0]       ienMask;
  logic [3:0]       evt;       // status bits 5:2, evt[0] = complete
  logic             wrCtrl, wrClr;

  wire unusedWdata = &{1'b0, regWdata[REG_DW-1:ROW_W], regWdata[31:13]};

  assign wrCtrl  = regWr && (regAddr == RA_CTRL);
  assign wrClr   = regWr && (regAddr == RA_ICLR);
  assign start   = wrCtrl && regWdata[7] && !busy;
  assign startOp = regWdata[12:8];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg    <= '0;
      wideReg  <= 1'b0;
      extraCyc <= '0;
      pageSel  <= '0;
      pageReg  <= '0;
      ienOn    <= 1'b0;
      ienMask  <= '0;
      evt      <= '0;
    end else begin
      if (start) opReg <= startOp;
      if (regWr && regAddr == RA_WIDTH) wideReg <= regWdata[0];
      if (regWr && regAddr == RA_GEOM) begin
        extraCyc <= regWdata[11:10];
        pageSel  <= regWdata[9:8];
      end
      if (regWr && regAddr == RA_PAGE) pageReg <= regWdata[ROW_W-1:0];
      if (regWr && regAddr == RA_IEN) begin
        ienOn   <= regWdata[7];
        ienMask <= regWdata[3:0];
      end
      if (wrClr) evt <= evt & ~regWdata[3:0];
      if (start) evt[0] <= 1'b0;
      if (cmdDone) evt[0] <= 1'b1;
    end
  end

  assign irq        = ienOn && |(ienMask & evt);
  assign wide       = wideReg;
  assign addrCycles = 3'd3 + {1'b0, extraCyc};
  assign rowAddr    = pageReg;

  always_comb begin
    case (pageSel)
      2'd0:    spareCol = COL_W'(512);
      2'd2:    spareCol = COL_W'(4096);
      default: spareCol = COL_W'(2048);
    endcase
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      RA_STATUS: regRdata[5:2] = evt;
      RA_CTRL:   regRdata[12:8] = opReg;
      RA_WIDTH:  regRdata[0] = wideReg;
      RA_GEOM:   regRdata[11:8] = {extraCyc, pageSel};
      RA_PAGE:   regRdata[ROW_W-1:0] = pageReg;
      RA_IDLO:   regRdata = idLo;
      RA_IDHI:   regRdata = idHi;
      RA_IEN:    regRdata[7:0] = {ienOn, 3'b000, ienMask};
      default:   regRdata = '0;
    endcase
  end

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> busy);
  // R10
  start_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !cmdDone) |=> !evt[0]);
  // R10
  done_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> evt[0]);
  // R11
  clear_works_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrClr && regWdata[0] && !cmdDone) |=> !evt[0]);

endmodule

// File: rtl/nandSeqCtrl.sv
module nandSeqCtrl
  import nandSeqPkg::*;
#(
  parameter int ROW_W = 26,
  parameter int COL_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [4:0]       startOp,
  input  logic             wide,
  input  logic [2:0]       addrCycles,
  input  logic [COL_W-1:0] spareCol,
  input  logic [ROW_W-1:0] rowAddr,
  input  logic             dataDone,
  output pinCtl_t          pinCtl,
  output logic             busy,
  output logic             cmdDone,
  output logic             dataActive,
  output logic             dataWrite
);

  logic       running;
  logic [4:0] op;
  logic [2:0] ph;
  logic [2:0] sub;
  logic       half;
  phase_t     cur;
  logic [2:0] rowBytes, subCount, byteSel;
  logic       isWrite, isRead, isBus, stepLast;
  logic [COL_W-1:0] colAddr;
  logic [7:0] addrByte;

  wire unusedRow = &{1'b0, rowAddr[ROW_W-1:24]};

  assign cur = phaseOf(op, ph);

  always_comb begin
    if (addrCycles >= 3'd5)      rowBytes = 3'd3;
    else if (addrCycles == 3'd4) rowBytes = 3'd2;
    else                         rowBytes = 3'd1;
  end

  always_comb begin
    case (cur.kind)
      K_ADDR_FULL: subCount = 3'(rowBytes + 3'd2);
      K_ADDR_ROW:  subCount = rowBytes;
      K_READ_ID:   subCount = wide ? 3'd3 : 3'd5;
      default:     subCount = 3'd1;
    endcase
  end

  assign isWrite  = (cur.kind == K_CMD) || (cur.kind == K_ADDR_FULL) ||
                    (cur.kind == K_ADDR_ROW) || (cur.kind == K_ADDR_ID);
  assign isRead   = (cur.kind == K_READ_ID) || (cur.kind == K_READ_ST);
  assign isBus    = running && (isWrite || isRead);
  assign stepLast = (sub == 3'(subCount - 3'd1));
  assign colAddr  = cur.spareCol ? spareCol : '0;
  assign byteSel  = (cur.kind == K_ADDR_ROW) ? 3'(sub + 3'd2) : sub;

  always_comb begin
    case (byteSel)
      3'd0:    addrByte = colAddr[7:0];
      3'd1:    addrByte = colAddr[15:8];
      3'd2:    addrByte = rowAddr[7:0];
      3'd3:    addrByte = rowAddr[15:8];
      default: addrByte = rowAddr[23:16];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      op      <= '0;
      ph      <= '0;
      sub     <= '0;
      half    <= 1'b0;
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        op      <= startOp;
        ph      <= '0;
        sub     <= '0;
        half    <= 1'b0;
      end
    end else if (cur.kind == K_END) begin
      running <= 1'b0;
    end else if (cur.kind == K_WAIT) begin
      if (dataDone) ph <= 3'(ph + 3'd1);
    end else begin
      half <= ~half;
      if (half) begin
        if (stepLast) begin
          ph  <= 3'(ph + 3'd1);
          sub <= '0;
        end else begin
          sub <= 3'(sub + 3'd1);
        end
      end
    end
  end

  assign busy       = running;
  assign cmdDone    = running && (cur.kind == K_END);
  assign dataActive = running && (cur.kind == K_WAIT);
  assign dataWrite  = dataActive && (op == OP_PROGRAM);

  always_comb begin
    pinCtl = '0;
    pinCtl.select    = running && (cur.kind != K_END);
    pinCtl.cmdLatch  = running && (cur.kind == K_CMD);
    pinCtl.addrLatch = running && isWrite && (cur.kind != K_CMD);
    pinCtl.wrStrobe  = isBus && isWrite && !half;
    pinCtl.rdStrobe  = isBus && isRead && !half;
    if (cur.kind == K_CMD)    pinCtl.ioByte = cur.code;
    else if (isWrite)         pinCtl.ioByte = (cur.kind == K_ADDR_ID) ? 8'h00 : addrByte;
    if (cur.kind == K_READ_ID) pinCtl.capSel = CAP_ID;
    if (cur.kind == K_READ_ST) pinCtl.capSel = CAP_STAT;
    pinCtl.capIdx = sub;
  end

  // R13
  op_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |=> (!running || $stable(op)));
  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataActive && !dataDone) |=> dataActive);
  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> !busy);

endmodule

// File: rtl/nandSeqPins.sv
module nandSeqPins
  import nandSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pinCtl_t           pinCtl,
  input  logic              wide,
  input  logic [IO_W-1:0]   ioIn,
  output logic              ceN,
  output logic              cle,
  output logic              ale,
  output logic              weN,
  output logic              reN,
  output logic [IO_W-1:0]   ioOut,
  output logic              ioOe,
  output logic [REG_DW-1:0] idLo,
  output logic [REG_DW-1:0] idHi
);

  capSel_e    capSelQ;
  logic [2:0] capIdxQ;
  logic       capNow;

  assign capNow = !reN && (capSelQ != CAP_NONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ceN     <= 1'b1;
      cle     <= 1'b0;
      ale     <= 1'b0;
      weN     <= 1'b1;
      reN     <= 1'b1;
      ioOut   <= '0;
      ioOe    <= 1'b0;
      capSelQ <= CAP_NONE;
      capIdxQ <= '0;
    end else begin
      ceN     <= !pinCtl.select;
      cle     <= pinCtl.cmdLatch;
      ale     <= pinCtl.addrLatch;
      weN     <= !pinCtl.wrStrobe;
      reN     <= !pinCtl.rdStrobe;
      ioOut   <= {{(IO_W-8){1'b0}}, pinCtl.ioByte};
      ioOe    <= pinCtl.select && (pinCtl.cmdLatch || pinCtl.addrLatch);
      capSelQ <= pinCtl.capSel;
      capIdxQ <= pinCtl.capIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idLo <= '0;
      idHi <= '0;
    end else if (capNow) begin
      if (capSelQ == CAP_STAT) begin
        idHi <= wide ? {16'h0, ioIn} : {24'h0, ioIn[7:0]};
      end else if (wide) begin
        case (capIdxQ)
          3'd0:    idLo[15:0]  <= ioIn;
          3'd1:    idLo[31:16] <= ioIn;
          default: idHi <= {16'h0, ioIn};
        endcase
      end else begin
        case (capIdxQ)
          3'd0:    idLo[7:0]   <= ioIn[7:0];
          3'd1:    idLo[15:8]  <= ioIn[7:0];
          3'd2:    idLo[23:16] <= ioIn[7:0];
          3'd3:    idLo[31:24] <= ioIn[7:0];
          default: idHi <= {24'h0, ioIn[7:0]};
        endcase
      end
    end
  end

  // R14
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!weN && !reN));
  // R14
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !weN |=> weN);
  // R14
  re_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reN |=> reN);
  // R14
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cle && ale));
  // R14
  select_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!weN || !reN) |-> !ceN);

endmodule

// File: rtl/nandCmdSeq.sv
module nandCmdSeq
  import nandSeqPkg::*;
#(
  parameter int ROW_W = 26,
  parameter int COL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWdata,
  output logic [REG_DW-1:0] regRdata,
  output logic              irq,
  input  logic              dataDone,
  output logic              dataActive,
  output logic              dataWrite,
  output logic              flashCeN,
  output logic              flashCle,
  output logic              flashAle,
  output logic              flashWeN,
  output logic              flashReN,
  output logic [IO_W-1:0]   flashIoOut,
  output logic              flashIoOe,
  input  logic [IO_W-1:0]   flashIoIn
);

  pinCtl_t          pinCtl;
  logic             busy, cmdDone, start, wide;
  logic [4:0]       startOp;
  logic [2:0]       addrCycles;
  logic [COL_W-1:0] spareCol;
  logic [ROW_W-1:0] rowAddr;
  logic [REG_DW-1:0] idLo, idHi;

  nandSeqRegs #(.ROW_W(ROW_W), .COL_W(COL_W)) uRegs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .busy(busy),
    .cmdDone(cmdDone), .idLo(idLo), .idHi(idHi), .start(start),
    .startOp(startOp), .wide(wide), .addrCycles(addrCycles),
    .spareCol(spareCol), .rowAddr(rowAddr)
  );

  nandSeqCtrl #(.ROW_W(ROW_W), .COL_W(COL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .startOp(startOp), .wide(wide),
    .addrCycles(addrCycles), .spareCol(spareCol), .rowAddr(rowAddr),
    .dataDone(dataDone), .pinCtl(pinCtl), .busy(busy), .cmdDone(cmdDone),
    .dataActive(dataActive), .dataWrite(dataWrite)
  );

  nandSeqPins uPins (
    .clk(clk), .rstN(rstN), .pinCtl(pinCtl), .wide(wide), .ioIn(flashIoIn),
    .ceN(flashCeN), .cle(flashCle), .ale(flashAle), .weN(flashWeN),
    .reN(flashReN), .ioOut(flashIoOut), .ioOe(flashIoOe),
    .idLo(idLo), .idHi(idHi)
  );

endmodule

// File: tb/tb_nandCmdSeq.sv
module tb_nandCmdSeq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irq, dataActive, dataWrite;
  logic        dataDone = 1'b0;
  logic        flashCeN, flashCle, flashAle, flashWeN, flashReN, flashIoOe;
  logic [15:0] flashIoOut;
  logic [15:0] flashIoIn = '0;

  int checks = 0;
  int errors = 0;
  logic [9:0] logMem [64];
  int logN = 0;
  int rdCount = 0;
  int protoErr = 0;
  logic prevWeLow = 1'b0;
  logic [9:0] expQ [$];

  always #2 clk = ~clk;

  nandCmdSeq dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq),
    .dataDone(dataDone), .dataActive(dataActive), .dataWrite(dataWrite),
    .flashCeN(flashCeN), .flashCle(flashCle), .flashAle(flashAle),
    .flashWeN(flashWeN), .flashReN(flashReN), .flashIoOut(flashIoOut),
    .flashIoOe(flashIoOe), .flashIoIn(flashIoIn)
  );

  // Flash model: logs write cycles, answers read cycles
  always @(negedge clk) begin
    if (rstN) begin
      if (!flashWeN) begin
        if (flashCeN || (flashCle && flashAle) || prevWeLow) protoErr++;
        if (logN < 64) logMem[logN] = {flashCle, flashAle, flashIoOut[7:0]};
        logN++;
      end
      prevWeLow = !flashWeN;
      if (!flashReN) begin
        if (flashCeN) protoErr++;
        flashIoIn = 16'h1234 + 16'(rdCount) * 16'h1111;
        rdCount++;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic clearLog();
    logN = 0; rdCount = 0; expQ.delete();
  endtask

  task automatic startOp(input logic [4:0] op);
    regWrite(4'h1, 32'h80 | (32'(op) << 8));
  endtask

  task automatic waitDone(input string tag);
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      regRead(4'h0, s);
      if (s[2]) break;
    end
    check(s[2], tag, s, 32'h4);
  endtask

  task automatic compareLog(input string tag);
    check(logN == expQ.size(), tag, 32'(logN), 32'(expQ.size()));
    for (int i = 0; i < expQ.size() && i < logN; i++)
      check(logMem[i] == expQ[i], tag, 32'(logMem[i]), 32'(expQ[i]));
    expQ.delete();
  endtask

  task automatic pulseDone();
    @(negedge clk); dataDone = 1'b1;
    @(negedge clk); dataDone = 1'b0;
  endtask

  task automatic pushAddr(input logic [15:0] col, input int rows, input logic [25:0] row);
    expQ.push_back(10'h100 | 10'(col[7:0]));
    expQ.push_back(10'h100 | 10'(col[15:8]));
    for (int i = 0; i < rows; i++) expQ.push_back(10'h100 | 10'((row >> (8*i)) & 26'hFF));
  endtask

  localparam logic [25:0] PG = 26'h2A5C3B1;

  task automatic testResetState();
    logic [31:0] d;
    regRead(4'h0, d); check(d == 0, "R10 reset status", d, 0);
    regRead(4'h1, d); check(d == 0, "R1 reset ctrl", d, 0);
    check(irq == 0, "R11 reset irq", 32'(irq), 0);
    check(flashCeN && flashWeN && flashReN, "R14 reset pins", {29'h0, flashCeN, flashWeN, flashReN}, 7);
  endtask

  task automatic testResetCmd();
    logic [31:0] d;
    clearLog();
    startOp(5'h02);
    regRead(4'h0, d); check(d[2] == 0, "R10 start clears", d, 0);
    waitDone("R2 done");
    expQ.push_back(10'h2FF); compareLog("R2 seq");
    regRead(4'h1, d); check(d == 32'h0200, "R1 readback", d, 32'h0200);
    check(flashCeN && !flashCle && !flashAle, "R10 idle pins", {29'h0, flashCeN, flashCle, flashAle}, 4);
  endtask

  task automatic testNoStart();
    logic [31:0] d;
    clearLog();
    regWrite(4'h1, 32'h0000_0400);
    repeat (10) @(negedge clk);
    check(logN == 0, "R1 no bit7 no cycles", 32'(logN), 0);
    regRead(4'h1, d); check(d == 32'h0200, "R1 no bit7 opcode kept", d, 32'h0200);
  endtask

  task automatic testReadId(input logic wideMode);
    logic [31:0] d;
    clearLog();
    regWrite(4'h2, {31'h0, wideMode});
    startOp(5'h01);
    waitDone("R3 done");
    expQ.push_back(10'h290); expQ.push_back(10'h100); compareLog("R3 seq");
    check(rdCount == (wideMode ? 3 : 5), "R3 read count", 32'(rdCount), wideMode ? 3 : 5);
    regRead(4'h5, d);
    check(d == (wideMode ? 32'h2345_1234 : 32'h6756_4534), "R3 id low", d, wideMode ? 32'h2345_1234 : 32'h6756_4534);
    regRead(4'h6, d);
    check(d == (wideMode ? 32'h3456 : 32'h78), "R3 id high", d, wideMode ? 32'h3456 : 32'h78);
    regWrite(4'h2, 32'h0);
  endtask

  task automatic testStatus();
    logic [31:0] d;
    clearLog();
    startOp(5'h04);
    waitDone("R4 done");
    expQ.push_back(10'h270); compareLog("R4 seq");
    check(rdCount == 1, "R4 reads", 32'(rdCount), 1);
    regRead(4'h6, d); check(d == 32'h34, "R4 status word", d, 32'h34);
  endtask

  task automatic testErase(input logic [1:0] extra);
    int rows;
    rows = (extra == 0) ? 1 : (extra == 1) ? 2 : 3;
    clearLog();
    regWrite(4'h3, 32'(extra) << 10);
    regWrite(4'h4, 32'(PG));
    startOp(5'h11);
    waitDone("R6 done");
    expQ.push_back(10'h260);
    for (int i = 0; i < rows; i++) expQ.push_back(10'h100 | 10'((PG >> (8*i)) & 26'hFF));
    expQ.push_back(10'h2D0); expQ.push_back(10'h270);
    compareLog("R5 R6 erase seq");
    check(rdCount == 1, "R6 chained read", 32'(rdCount), 1);
  endtask

  task automatic testReadPage();
    logic [31:0] d;
    clearLog();
    regWrite(4'h3, 32'h900);
    startOp(5'h05);
    repeat (30) @(negedge clk);
    regRead(4'h0, d); check(d[2] == 0, "R7 busy no complete", d, 0);
    check(dataActive && !dataWrite, "R7 data phase", {30'h0, dataActive, dataWrite}, 2);
    regWrite(4'h1, 32'h0280);
    repeat (10) @(negedge clk);
    regRead(4'h1, d); check(d == 32'h0500, "R13 opcode kept", d, 32'h0500);
    check(logN == 7, "R13 no extra cycles", 32'(logN), 7);
    pulseDone();
    waitDone("R7 done");
    expQ.push_back(10'h200); pushAddr(16'h0, 3, PG); expQ.push_back(10'h230);
    compareLog("R5 R7 seq");
    check(!dataActive, "R7 data phase ends", 32'(dataActive), 0);
  endtask

  task automatic testProgram();
    for (int i = 0; i < 100 && !dataActive; i++) @(negedge clk);
  endtask

  task automatic testProgramCmd();
    clearLog();
    regWrite(4'h3, 32'h900);
    startOp(5'h10);
    testProgram();
    check(dataActive && dataWrite, "R8 write phase", {30'h0, dataActive, dataWrite}, 3);
    check(logN == 6, "R8 before data", 32'(logN), 6);
    pulseDone();
    waitDone("R8 done");
    expQ.push_back(10'h280); pushAddr(16'h0, 3, PG);
    expQ.push_back(10'h210); expQ.push_back(10'h270);
    compareLog("R8 seq");
    check(rdCount == 1, "R8 chained read", 32'(rdCount), 1);
  endtask

  task automatic testSpare();
    clearLog();
    regWrite(4'h3, 32'h000);
    startOp(5'h06);
    waitDone("R9 done");
    expQ.push_back(10'h200); pushAddr(16'd512, 1, PG); expQ.push_back(10'h230);
    compareLog("R9 spare read 512");
    clearLog();
    regWrite(4'h3, 32'h900);
    startOp(5'h06);
    waitDone("R9 done");
    expQ.push_back(10'h200); pushAddr(16'd2048, 3, PG); expQ.push_back(10'h230);
    compareLog("R9 spare read 2048");
    clearLog();
    regWrite(4'h3, 32'h600);
    startOp(5'h13);
    waitDone("R9 done");
    expQ.push_back(10'h280); pushAddr(16'd4096, 2, PG);
    expQ.push_back(10'h210); expQ.push_back(10'h270);
    compareLog("R9 spare write 4096");
    check(rdCount == 1, "R9 chained read", 32'(rdCount), 1);
  endtask

  task automatic testUnknown();
    clearLog();
    startOp(5'h07);
    waitDone("R12 done");
    check(logN == 0 && rdCount == 0, "R12 no cycles", 32'(logN + rdCount), 0);
  endtask

  task automatic testIrq();
    logic [31:0] d;
    regWrite(4'h7, 32'h01);
    check(irq == 0, "R11 master off", 32'(irq), 0);
    regWrite(4'h7, 32'h81);
    check(irq == 1, "R11 enabled", 32'(irq), 1);
    regWrite(4'h7, 32'h82);
    check(irq == 0, "R11 other mask", 32'(irq), 0);
    regWrite(4'h7, 32'h81);
    regWrite(4'h8, 32'h1);
    regRead(4'h0, d); check(d == 0, "R11 clear status", d, 0);
    check(irq == 0, "R11 clear irq", 32'(irq), 0);
    startOp(5'h02);
    waitDone("R11 done");
    check(irq == 1, "R11 irq on completion", 32'(irq), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testResetState();
    testResetCmd();
    testNoStart();
    testReadId(1'b0);
    testReadId(1'b1);
    testStatus();
    testErase(2'd0);
    testErase(2'd1);
    testErase(2'd2);
    testErase(2'd3);
    testReadPage();
    testProgramCmd();
    testSpare();
    testUnknown();
    testIrq();
    check(protoErr == 0, "R14 pin protocol", 32'(protoErr), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule